// File: doc/BRIEF.md
# Edge and Level Input Interrupt Bank

This block watches a group of external input lines and turns chosen events on them into a single interrupt request. Each line is first brought into the system clock domain by a two-stage synchronizer. Each channel is then set to one of five detections: a rising edge, a falling edge, either edge, a high level or a low level. A detected event sets that channel's sticky status bit. Software reads status through a small register port, clears bits by writing ones, and gates which channels may raise the shared interrupt output.

The same logic also serves a capture variant whose clock is a slow sample clock, for example 32 kHz, instead of the bus clock. The register port is a plain single-cycle write strobe with combinational read data. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure. Register addresses are byte offsets, and the control fields of a channel sit at the channel's bit index in each register.

Top module: `irq_edge_bank`

## Requirements
- R1: The input-level register (offset 0x1C) shows each input through two flops. A value held at `chan_in` before clock edge k reads back after edge k+1, and the older value still reads back between edges k and k+1.
- R2: With mode bit 0, both-edge bit 0 and polarity bit 1, a low-to-high change of the synchronized level sets the channel's status bit. For an input change before edge k, the bit is visible after edge k+2.
- R3: With mode bit 0, both-edge bit 0 and polarity bit 0, only a high-to-low change sets the status bit. A rising change leaves it clear.
- R4: With mode bit 0 and both-edge bit 1, a rising change and a falling change each set the status bit, whatever the polarity bit holds.
- R5: With mode bit 1, status is set on every cycle in which the synchronized level equals the polarity bit (1 = high, 0 = low). This includes a level that is already present when level mode is selected.
- R6: A status bit, once set, stays set until a write to the clear register (0x0C) with a 1 at that bit. Zeros in the clear write, and writes to any other offset, leave status unchanged.
- R7: A detection in the same cycle as a clear of the same bit leaves the bit set. In level mode, a clear therefore holds only once the level is inactive.
- R8: The masked register (0x08) reads raw status (0x04) ANDed with the enable register (0x00). `irq_out` is high exactly when any masked bit is set.
- R9: Enable (0x00), mode (0x10), both-edge (0x14) and polarity (0x18) are read/write. Writes to raw, masked or input-level offsets are ignored. The clear offset and unmapped offsets read zero.
- R10: After reset, every register reads zero and `irq_out` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System or sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_in | input | NCH | Asynchronous external input lines |
| reg_wr_en | input | 1 | Write strobe for one cycle |
| reg_addr | input | ADDR_W | Register byte offset for both read and write |
| reg_wdata | input | NCH | Write data, one bit per channel |
| reg_rdata | output | NCH | Combinational read data for `reg_addr` |
| irq_out | output | 1 | Shared interrupt request |

## Verification
The collision that matters is a detection and a write-one-to-clear of the same status bit landing on the same clock edge. The bench provokes this by raising a rising-edge channel and timing the clear write to the edge on which the synchronized edge arrives, which is two edges after the input is sampled. It expects the bit still set afterwards. A level-mode channel gives the persistent form of the same collision: clears issued while the level is active must not stick. A behavioural reference that keeps a queue of sampled inputs judges every cycle's read data and interrupt against these rules.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  // Byte offsets of the register map
  localparam int unsigned OFS_ENABLE = 0;
  localparam int unsigned OFS_RAW    = 4;
  localparam int unsigned OFS_MASKED = 8;
  localparam int unsigned OFS_CLEAR  = 12;
  localparam int unsigned OFS_MODE   = 16;
  localparam int unsigned OFS_BOTH   = 20;
  localparam int unsigned OFS_POL    = 24;
  localparam int unsigned OFS_LEVEL  = 28;

  // Per-channel detection setup
  typedef struct packed {
    logic level;  // 1: level detect, 0: edge detect
    logic both;   // edge mode only: either edge
    logic pol;    // 1: rising/high, 0: falling/low
  } chan_cfg_t;

endpackage

// File: rtl/irq_bank_sync.sv
module irq_bank_sync #(
  parameter int unsigned NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] async_in,
  output logic [NCH-1:0] lvl,
  output logic [NCH-1:0] lvl_prev
);

  logic [NCH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      lvl      <= '0;
      lvl_prev <= '0;
    end else begin
      meta_q   <= async_in;
      lvl      <= meta_q;
      lvl_prev <= lvl;
    end
  end

endmodule

// File: rtl/irq_bank_detect.sv
module irq_bank_detect
  import irq_bank_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input  logic [NCH-1:0]  lvl,
  input  logic [NCH-1:0]  lvl_prev,
  input  chan_cfg_t [NCH-1:0] cfg,
  output logic [NCH-1:0]  hit
);

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic rise, fall;
    assign rise = lvl[c] & ~lvl_prev[c];
    assign fall = ~lvl[c] & lvl_prev[c];

    always_comb begin
      if (cfg[c].level)
        hit[c] = (lvl[c] == cfg[c].pol);
      else if (cfg[c].both)
        hit[c] = rise | fall;
      else
        hit[c] = cfg[c].pol ? rise : fall;
    end
  end

endmodule

// File: rtl/irq_bank_regs.sv
module irq_bank_regs
  import irq_bank_pkg::*;
#(
  parameter int unsigned NCH    = 8,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NCH-1:0]    wdata,
  input  logic [NCH-1:0]    hit,
  input  logic [NCH-1:0]    lvl,
  output logic [NCH-1:0]    rdata,
  output logic [NCH-1:0]    enable,
  output logic [NCH-1:0]    status,
  output chan_cfg_t [NCH-1:0] cfg
);

  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_ENABLE);
  localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(OFS_RAW);
  localparam logic [ADDR_W-1:0] A_MSK  = ADDR_W'(OFS_MASKED);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLEAR);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] A_BOTH = ADDR_W'(OFS_BOTH);
  localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(OFS_POL);
  localparam logic [ADDR_W-1:0] A_LVL  = ADDR_W'(OFS_LEVEL);

  logic [NCH-1:0] mode_q, both_q, pol_q, clr_mask;

  assign clr_mask = (wr_en && addr == A_CLR) ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= '0;
      mode_q <= '0;
      both_q <= '0;
      pol_q  <= '0;
      status <= '0;
    end else begin
      // a new detection wins over a clear of the same bit
      status <= (status & ~clr_mask) | hit;
      if (wr_en) begin
        unique case (addr)
          A_EN:    enable <= wdata;
          A_MODE:  mode_q <= wdata;
          A_BOTH:  both_q <= wdata;
          A_POL:   pol_q  <= wdata;
          default: ;
        endcase
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_cfg
    assign cfg[c] = '{level: mode_q[c], both: both_q[c], pol: pol_q[c]};
  end

  always_comb begin
    unique case (addr)
      A_EN:    rdata = enable;
      A_RAW:   rdata = status;
      A_MSK:   rdata = status & enable;
      A_MODE:  rdata = mode_q;
      A_BOTH:  rdata = both_q;
      A_POL:   rdata = pol_q;
      A_LVL:   rdata = lvl;
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_edge_bank.sv
module irq_edge_bank
  import irq_bank_pkg::*;
#(
  parameter int unsigned NCH    = 8,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    chan_in,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NCH-1:0]    reg_wdata,
  output logic [NCH-1:0]    reg_rdata,
  output logic              irq_out
);

  logic [NCH-1:0] sync_lvl, sync_prev, hit_vec, status_vec, enable_vec;
  chan_cfg_t [NCH-1:0] cfg_vec;

  irq_bank_sync #(.NCH(NCH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (chan_in),
    .lvl      (sync_lvl),
    .lvl_prev (sync_prev)
  );

  irq_bank_detect #(.NCH(NCH)) u_detect (
    .lvl      (sync_lvl),
    .lvl_prev (sync_prev),
    .cfg      (cfg_vec),
    .hit      (hit_vec)
  );

  irq_bank_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr_en),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .hit    (hit_vec),
    .lvl    (sync_lvl),
    .rdata  (reg_rdata),
    .enable (enable_vec),
    .status (status_vec),
    .cfg    (cfg_vec)
  );

  assign irq_out = |(status_vec & enable_vec);

endmodule

// File: rtl/irq_edge_bank_chk.sv
module irq_edge_bank_chk
  import irq_bank_pkg::*;
#(
  parameter int unsigned NCH    = 8,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    chan_in,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [NCH-1:0]    reg_wdata,
  input logic [NCH-1:0]    reg_rdata,
  input logic              irq_out,
  input logic [NCH-1:0]    status,
  input logic [NCH-1:0]    enable,
  input logic [NCH-1:0]    sync_lvl
);

  logic [NCH-1:0] clr_seen;
  logic [1:0]     since_rst;

  assign clr_seen = (reg_wr_en && reg_addr == ADDR_W'(OFS_CLEAR)) ? reg_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R6: only a written one clears a status bit
  a_r6_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((($past(status) & ~$past(clr_seen)) & ~status) == '0));

  // R1: level register lags the pins by two flops
  a_r1_sync_lag: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (sync_lvl == $past(chan_in, 2)));

  // R9: clear offset reads zero
  a_r9_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(OFS_CLEAR)) |-> (reg_rdata == '0));

  // R8: no request while every channel is disabled
  a_r8_gated_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> !irq_out);

endmodule

bind irq_edge_bank irq_edge_bank_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chan_in   (chan_in),
  .reg_wr_en (reg_wr_en),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq_out   (irq_out),
  .status    (status_vec),
  .enable    (enable_vec),
  .sync_lvl  (sync_lvl)
);

// File: tb/test_irq_edge_bank.sv
`timescale 1ns/1ps
module test_irq_edge_bank;

  localparam logic [4:0] EN = 5'h00, RAW = 5'h04, MSK = 5'h08, CLR = 5'h0C,
                         MODE = 5'h10, BOTH = 5'h14, POL = 5'h18, LVL = 5'h1C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] chan_in = '0;
  logic       reg_wr_en = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_edge_bank i_irq_edge_bank (
    .clk(clk), .rst_n(rst_n), .chan_in(chan_in), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  // behavioural reference: history of sampled pins, newest first
  logic [7:0] hist[$] = '{8'h00, 8'h00, 8'h00};
  logic [7:0] m_en = '0, m_mode = '0, m_both = '0, m_pol = '0, m_stat = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{8'h00, 8'h00, 8'h00};
      m_en = '0; m_mode = '0; m_both = '0; m_pol = '0; m_stat = '0;
    end else begin
      logic [7:0] hits, clr;
      hits = '0;
      for (int i = 0; i < 8; i++) begin
        bit now_l, old_l;
        now_l = hist[1][i];
        old_l = hist[2][i];
        if (m_mode[i]) hits[i] = (now_l == m_pol[i]);
        else if (m_both[i]) hits[i] = (now_l != old_l);
        else if (m_pol[i]) hits[i] = now_l && !old_l;
        else hits[i] = !now_l && old_l;
      end
      clr = (reg_wr_en && reg_addr == CLR) ? reg_wdata : 8'h00;
      m_stat = (m_stat & ~clr) | hits;
      if (reg_wr_en) begin
        case (reg_addr)
          EN:   m_en = reg_wdata;
          MODE: m_mode = reg_wdata;
          BOTH: m_both = reg_wdata;
          POL:  m_pol = reg_wdata;
          default: ;
        endcase
      end
      hist.push_front(chan_in);
      void'(hist.pop_back());
    end
  end

  function automatic logic [7:0] model_rd(input logic [4:0] a);
    case (a)
      EN:   return m_en;
      RAW:  return m_stat;
      MSK:  return m_stat & m_en;
      MODE: return m_mode;
      BOTH: return m_both;
      POL:  return m_pol;
      LVL:  return hist[1];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    #1;
    if (!done) begin
      string tag;
      chk("R8 irq per-cycle", {7'd0, irq_out}, {7'd0, |(m_stat & m_en)});
      case (reg_addr)
        LVL: tag = "R1 read per-cycle";
        RAW: tag = "R6 read per-cycle";
        MSK: tag = "R8 read per-cycle";
        default: tag = "R9 read per-cycle";
      endcase
      chk(tag, reg_rdata, model_rd(reg_addr));
    end
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] e, input string tag);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, e);
    @(negedge clk);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    rd(EN, 8'h00, "R10 enable"); rd(RAW, 8'h00, "R10 raw");
    rd(MODE, 8'h00, "R10 mode"); rd(POL, 8'h00, "R10 pol");
    chk("R10 irq", {7'd0, irq_out}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    wr(EN, 8'hFF); wr(POL, 8'h0F);
    rd(POL, 8'h0F, "R9 pol readback");

    // R2: rising on ch0
    chan_in = 8'h01; wait_n(4);
    rd(RAW, 8'h01, "R2 rise sets");
    chk("R8 irq high", {7'd0, irq_out}, 8'h01);
    rd(MSK, 8'h01, "R8 masked");
    wr(CLR, 8'h01);
    rd(RAW, 8'h00, "R6 clear one");

    // R3: falling only on ch4
    chan_in = 8'h11; wait_n(4);
    rd(RAW, 8'h00, "R3 rise ignored");
    chan_in = 8'h01; wait_n(4);
    rd(RAW, 8'h10, "R3 fall sets");
    wr(CLR, 8'h00);
    rd(RAW, 8'h10, "R6 zero write keeps");
    wr(CLR, 8'h10);
    rd(RAW, 8'h00, "R6 cleared");

    // R4: both edges on ch1 with rising polarity
    wr(BOTH, 8'h02);
    chan_in = 8'h03; wait_n(4);
    rd(RAW, 8'h02, "R4 rise");
    wr(CLR, 8'h02);
    chan_in = 8'h01; wait_n(4);
    rd(RAW, 8'h02, "R4 fall overrides pol");
    wr(CLR, 8'h02);
    rd(RAW, 8'h00, "R4 cleared");

    // R5/R7: level high on ch2
    wr(MODE, 8'h04);
    chan_in = 8'h05; wait_n(4);
    rd(RAW, 8'h04, "R5 level high");
    wr(CLR, 8'h04); wait_n(1);
    rd(RAW, 8'h04, "R7 clear while active");
    chan_in = 8'h01; wait_n(4);
    wr(CLR, 8'h04);
    rd(RAW, 8'h00, "R7 clear after inactive");

    // R5: level low on ch7 already present
    wr(MODE, 8'h84); wait_n(3);
    rd(RAW, 8'h80, "R5 level low present");
    wr(EN, 8'h00);
    rd(MSK, 8'h00, "R8 masked gated");
    chk("R8 irq gated", {7'd0, irq_out}, 8'h00);
    rd(RAW, 8'h80, "R8 raw ungated");
    wr(EN, 8'h80);
    chk("R8 irq enabled", {7'd0, irq_out}, 8'h01);
    chan_in = 8'h81; wait_n(4);
    wr(CLR, 8'h80);
    rd(RAW, 8'h00, "R5 level gone");
    wr(MODE, 8'h00); wr(EN, 8'hFF);

    // R7: detection and clear on the same edge (ch3 rising)
    chan_in = 8'h89;
    wait_n(2);
    wr(CLR, 8'h08);
    rd(RAW, 8'h08, "R7 set beats clear");
    wr(CLR, 8'h08);
    rd(RAW, 8'h00, "R7 later clear");

    // R9: read-only and unmapped offsets
    wr(RAW, 8'hFF); wr(LVL, 8'h00); wr(5'h02, 8'hFF);
    rd(RAW, 8'h00, "R9 raw write ignored");
    rd(CLR, 8'h00, "R9 clear reads zero");
    rd(5'h02, 8'h00, "R9 unmapped");
    rd(EN, 8'hFF, "R9 enable"); rd(BOTH, 8'h02, "R9 both");

    // R1: two-flop lag on the level register
    reg_addr = LVL;
    #1; chk("R1 level before", reg_rdata, 8'h89);
    @(negedge clk);
    chan_in = 8'h88;
    @(negedge clk); #1;
    chk("R1 one edge later", reg_rdata, 8'h89);
    @(negedge clk); #1;
    chk("R1 two edges later", reg_rdata, 8'h88);
    @(negedge clk);
    rd(RAW, 8'h00, "R2 no rise on fall");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule